// File: doc/BRIEF.md
# Hysteretic Stochastic Bitstream Rerandomizer

This block merges two stochastic bitstreams in the manner of a Muller C-element and produces a new stream that encodes about the same probability with shorter runs of equal bits. When the two input bits agree, the cycle is called regenerative. The shared bit is passed to the output and also latched as the held regenerative bit. When the inputs disagree, the block does not simply repeat the last output. Instead it sends out a fresh random bit, which is 1 when a random number falls below a saturating sum counter.

The sum counter tracks the running balance between the held regenerative bit and the generated bits. A build-time mode parameter picks one of two update rules. The single-ended rule counts only 1 bits from each source. The differential rule counts both polarities from each source. Random numbers come from an internal linear-feedback shift register, so a run is fully reproducible after every reset. Blocks of this kind are chained as nodes of a stochastic inference tree, with one block per two-input merge.

Top module: `stoch_rerand`

## Requirements
- R1: While rst_n is low, c_out is 0. Reset sets the sum counter S to mid-scale 2^(CNT_W-1), sets the held bit g to 0 and loads the random generator with LFSR_SEED.
- R2: A cycle is regenerative when a_in equals b_in. After such a cycle's clock edge, c_out equals that cycle's a_in. The output is registered, so c_out shows each cycle's decision one edge later.
- R3: g takes the value of a_in only on regenerative cycles. A non-regenerative cycle leaves g unchanged.
- R4: On a non-regenerative cycle, the output bit is rh, where rh = 1 when r < S (unsigned) and rh = 0 otherwise. Here r is the CNT_W least significant bits of the generator state in that cycle.
- R5: In single-ended mode (MODE = CNT_SINGLE), S gains 1 when g is 1 and loses 1 when rh is 1. When both happen in the same cycle, S stays the same.
- R6: In differential mode (MODE = CNT_DIFF), g adds +1 when it is 1 and -1 when it is 0. rh adds -1 when it is 1 and +1 when it is 0. Both contributions are applied in the same cycle, so S changes by -2, 0 or +2.
- R7: S saturates at 0 and at 2^CNT_W-1. It never wraps.
- R8: The update of S in a cycle uses g as it stands after that cycle's conditional load, together with the rh value of the same cycle. rh is computed from S before the update.
- R9: The generator is a 16-bit shift register that moves one place toward the MSB on every cycle out of reset. Its new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10, and its state is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 1 | First stochastic input stream |
| b_in | input | 1 | Second stochastic input stream |
| c_out | output | 1 | Registered rerandomized output stream |

## Verification
Both modes are driven with the same stimulus and compared cycle by cycle against a reference model built from the requirements. Long runs of agreeing bits check that regenerative values pass through unchanged. Long runs of disagreeing bits expose the comparator and the counter rules, because the generated bits then depend on S alone. A stretch of disagreement held after a stored 0 drains S to its floor, and one held after a stored 1 drives S to its ceiling, which separates saturation from wrap-around. A single agreeing cycle followed directly by a disagreeing one shows whether the counter uses the freshly loaded g. A mixed pseudo-random input pattern and a reset in the middle of a run cover the general case and the return to the reset state.

// File: rtl/stoch_rerand_pkg.sv
package stoch_rerand_pkg;

  typedef enum logic {
    CNT_SINGLE = 1'b0,
    CNT_DIFF   = 1'b1
  } cnt_mode_e;

  localparam int RND_W = 16;

endpackage

// File: rtl/rr_lfsr.sv
module rr_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] state_o
);

  logic [15:0] state_q;
  logic [15:0] state_d;
  logic        fb;

  always_comb begin
    fb      = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
    state_d = {state_q[14:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 16'h0000);

endmodule

// File: rtl/rr_regen_path.sv
module rr_regen_path #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_i,
  input  logic             b_i,
  input  logic [CNT_W-1:0] rnd_i,
  input  logic [CNT_W-1:0] sum_i,
  output logic             g_next_o,
  output logic             rh_o,
  output logic             c_o
);

  logic regen;
  logic g_q;
  logic g_d;
  logic g_en;
  logic rh;
  logic c_q;
  logic c_d;

  always_comb begin
    regen = ~(a_i ^ b_i);
    g_en  = regen;
    g_d   = g_en ? a_i : g_q;
    rh    = (rnd_i < sum_i);
    c_d   = regen ? g_d : rh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    g_q <= 1'b0;
    else if (g_en) g_q <= g_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= 1'b0;
    else        c_q <= c_d;
  end

  assign g_next_o = g_d;
  assign rh_o     = rh;
  assign c_o      = c_q;

  assert_regen_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i == b_i) |=> (c_q == $past(a_i)));

  assert_hold_g_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i != b_i) |=> $stable(g_q));

  assert_empty_sum_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_i != b_i) && (sum_i == '0)) |=> !c_q);

endmodule

// File: rtl/rr_sum_counter.sv
module rr_sum_counter
  import stoch_rerand_pkg::*;
#(
  parameter int        CNT_W = 4,
  parameter cnt_mode_e MODE  = CNT_SINGLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             g_i,
  input  logic             rh_i,
  output logic [CNT_W-1:0] sum_o
);

  localparam int MAXV     = (1 << CNT_W) - 1;
  localparam int MIDV     = 1 << (CNT_W - 1);
  localparam int STEP_MAX = (MODE == CNT_DIFF) ? 2 : 1;

  logic [CNT_W-1:0] s_q;
  logic [CNT_W-1:0] s_d;
  int               step;
  int               raw;

  generate
    if (MODE == CNT_DIFF) begin : g_diff
      always_comb begin
        step = (g_i ? 1 : -1) + (rh_i ? -1 : 1);
      end
    end else begin : g_single
      always_comb begin
        step = (g_i ? 1 : 0) - (rh_i ? 1 : 0);
      end
    end
  endgenerate

  always_comb begin
    raw = int'(s_q) + step;
    if (raw > MAXV)   s_d = CNT_W'(MAXV);
    else if (raw < 0) s_d = '0;
    else              s_d = raw[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= CNT_W'(MIDV);
    else        s_q <= s_d;
  end

  assign sum_o = s_q;

  assert_step_bound_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int'(s_q) - int'($past(s_q)) <= STEP_MAX) &&
              (int'(s_q) - int'($past(s_q)) >= -STEP_MAX)));

  assert_ceiling_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_q == CNT_W'(MAXV)) && g_i && !rh_i) |=> (s_q == CNT_W'(MAXV)));

  assert_floor_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_q == '0) && !g_i) |=> (s_q == '0));

endmodule

// File: rtl/stoch_rerand.sv
module stoch_rerand
  import stoch_rerand_pkg::*;
#(
  parameter int          CNT_W     = 4,
  parameter cnt_mode_e   MODE      = CNT_SINGLE,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_in,
  input  logic b_in,
  output logic c_out
);

  logic [RND_W-1:0] rnd_state;
  logic [CNT_W-1:0] rnd;
  logic [CNT_W-1:0] sum;
  logic             g_next;
  logic             rh;

  assign rnd = rnd_state[CNT_W-1:0];

  rr_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_o (rnd_state)
  );

  rr_regen_path #(.CNT_W(CNT_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_i      (a_in),
    .b_i      (b_in),
    .rnd_i    (rnd),
    .sum_i    (sum),
    .g_next_o (g_next),
    .rh_o     (rh),
    .c_o      (c_out)
  );

  rr_sum_counter #(.CNT_W(CNT_W), .MODE(MODE)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .g_i   (g_next),
    .rh_i  (rh),
    .sum_o (sum)
  );

endmodule

// File: tb/stoch_rerand_bench.sv
module stoch_rerand_bench;
  import stoch_rerand_pkg::*;

  localparam int CNT_W = 4;
  localparam int MAXV  = (1 << CNT_W) - 1;
  localparam int MIDV  = 1 << (CNT_W - 1);
  localparam logic [15:0] SEED = 16'hACE1;

  // table entry: [9]=a, [8]=b, [7:0]=cycles
  localparam logic [9:0] VEC [16] = '{
    {1'b1, 1'b1, 8'd3},  {1'b1, 1'b0, 8'd20}, {1'b0, 1'b0, 8'd2},  {1'b0, 1'b1, 8'd25},
    {1'b1, 1'b1, 8'd1},  {1'b0, 1'b1, 8'd1},  {1'b0, 1'b0, 8'd1},  {1'b1, 1'b0, 8'd1},
    {1'b1, 1'b1, 8'd6},  {1'b0, 1'b1, 8'd40}, {1'b0, 1'b0, 8'd5},  {1'b1, 1'b0, 8'd40},
    {1'b1, 1'b1, 8'd1},  {1'b1, 1'b0, 8'd3},  {1'b0, 1'b0, 8'd1},  {1'b0, 1'b1, 8'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_in = 1'b0;
  logic b_in = 1'b0;
  logic c_se;
  logic c_df;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int          m_s [2];
  bit          m_g [2];
  logic [15:0] m_lfsr;

  always #5 clk = ~clk;

  stoch_rerand #(.CNT_W(CNT_W), .MODE(CNT_SINGLE), .LFSR_SEED(SEED)) u_stoch_rerand (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .c_out(c_se));

  stoch_rerand #(.CNT_W(CNT_W), .MODE(CNT_DIFF), .LFSR_SEED(SEED)) u_stoch_rerand_diff (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .c_out(c_df));

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic model_init();
    for (int md = 0; md < 2; md++) begin
      m_s[md] = MIDV;
      m_g[md] = 1'b0;
    end
    m_lfsr = SEED;
  endtask

  // R1..R9 reference model of one clock edge
  task automatic model_cycle(input logic a, input logic b, output logic e0, output logic e1);
    int  r;
    bit  regen, gn, rh;
    int  st, ns;
    logic fb;
    logic e [2];
    r = int'(m_lfsr[CNT_W-1:0]);
    regen = (a == b);
    for (int md = 0; md < 2; md++) begin
      gn = regen ? a : m_g[md];
      rh = (r < m_s[md]);
      e[md] = regen ? gn : rh;
      if (md == 0) st = (gn ? 1 : 0) - (rh ? 1 : 0);
      else         st = (gn ? 1 : -1) + (rh ? -1 : 1);
      ns = m_s[md] + st;
      if (ns > MAXV) ns = MAXV;
      if (ns < 0)    ns = 0;
      m_s[md] = ns;
      m_g[md] = gn;
    end
    fb = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10];
    m_lfsr = {m_lfsr[14:0], fb};
    e0 = e[0];
    e1 = e[1];
  endtask

  task automatic step(input logic a, input logic b, input string tag);
    logic e0, e1;
    model_cycle(a, b, e0, e1);
    a_in = a;
    b_in = b;
    @(posedge clk);
    #1;
    check(c_se, e0, {tag, " single R5"});
    check(c_df, e1, {tag, " diff R6"});
    if (a == b) begin
      check(c_se, a, {tag, " R2 pass-through"});
      check(c_df, a, {tag, " R2 pass-through"});
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    a_in = 1'b0;
    b_in = 1'b0;
    #2;
    check(c_se, 1'b0, "R1 reset output single");
    check(c_df, 1'b0, "R1 reset output diff");
    repeat (3) @(posedge clk);
    #4;
    rst_n = 1'b1;
    model_init();
  endtask

  initial begin
    int lcg;
    logic ra, rb;
    #3;
    check(c_se, 1'b0, "R1 initial reset single");
    check(c_df, 1'b0, "R1 initial reset diff");
    do_reset();

    // R4 R9: first non-regenerative cycles from reset state
    step(1'b1, 1'b0, "R4 R9 first random bit");
    step(1'b0, 1'b1, "R4 R9 second random bit");

    // table walk
    foreach (VEC[i]) begin
      for (int k = 0; k < int'(VEC[i][7:0]); k++)
        step(VEC[i][9], VEC[i][8], "R3 R4 table");
    end

    // R7 floor: store 0, then long disagreement drains S to 0
    step(1'b0, 1'b0, "R3 store zero");
    for (int k = 0; k < 300; k++) step(1'b1, 1'b0, "R7 floor drain");
    for (int k = 0; k < 20; k++) begin
      step(1'b0, 1'b1, "R7 floor");
      check(c_se, 1'b0, "R7 floor output single");
      check(c_df, 1'b0, "R7 floor output diff");
    end

    // R8: single agreeing 1 right before disagreement
    step(1'b1, 1'b1, "R8 fresh load");
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1, "R8 after load");

    // R7 ceiling: stored 1 with long disagreement
    for (int k = 0; k < 300; k++) step(1'b1, 1'b0, "R7 ceiling");

    // mixed pseudo-random pattern
    lcg = 12345;
    for (int k = 0; k < 400; k++) begin
      lcg = lcg * 1103515245 + 12345;
      ra = lcg[16];
      rb = lcg[20];
      step(ra, rb, "R2 R3 R4 mixed");
    end

    // R1 reset in mid run, then restart from reset state
    do_reset();
    for (int k = 0; k < 30; k++) step(1'b0, 1'b1, "R1 R9 after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule